// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block drives a successive-approximation analog-to-digital converter from four word registers on a simple APB-style bus. Software picks a channel, arms the power bit and, if it wants an interrupt, the enable bit, all in a single control write. The block then holds off for a programmable settle count and resolves the result one bit per clock, starting at the MSB. It then stores the code, raises a sticky completion flag and, when enabled, drives the interrupt line.

The analog comparator is outside the block. The block presents a trial code and a channel number, and a one-bit answer comes back saying whether the sampled input is at or above that code. Writing zero to the control register clears the flag and powers the converter down. If that write arrives during a conversion, the conversion is abandoned and the previous result is kept.

The offsets are 0x00 for result, 0x04 for status, 0x08 for control and 0x0C for settle delay. The result width and the channel count are parameters, for example 10 bits with 3 inputs or 12 bits with 2.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the result, status and control registers read 0, the settle-delay register reads 8, and `irq` and `pwr_on` are low.
- R2: Reads use these layouts. Result (0x00) carries the code in bits RES_BITS-1:0, with the bits above it zero. Status (0x04) bit 0 is busy. Control (0x08) has the channel in bits 2:0, power in bit 3, interrupt enable in bit 5 and the completion flag in bit 6. Delay (0x0C) holds a 6-bit count in bits 5:0.
- R3: A control write with bit 3 set starts a conversion on the channel in bits 2:0, and status bit 0 reads 1 from the next cycle.
- R4: A conversion completes exactly D + RES_BITS clock edges after the edge that takes the starting write, where D is the delay register value; D = 0 starts the approximation at once.
- R5: The approximation tests one bit per cycle from MSB to LSB. A bit is kept when `cmp_ge` is 1 for the trial code, so the result is the largest code not above the comparator threshold.
- R6: On completion the result register loads the code and the control flag (bit 6) sets. `irq` equals flag AND enable, so clearing enable hides a pending flag and setting enable later shows it.
- R7: A control write with bit 6 at 0 clears the flag. Writing 0 also drops `pwr_on` and `irq`, while bit 6 written 1 leaves the flag as it was.
- R8: A control write with bit 3 clear during a conversion aborts it. Busy is 0 from the next cycle, the result register keeps its earlier value and no flag is raised.
- R9: A channel number at or above NUM_CH is accepted like any other, and `chan_sel` shows the written channel throughout the conversion.
- R10: Writes to the result and status registers have no effect, and reads from any offset other than the four defined ones return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W (5) | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high and pwrite low |
| cmp_ge | input | 1 | Comparator answer: input at or above `trial_code` |
| trial_code | output | RES_BITS (10) | Code under test, 0 outside the approximation |
| chan_sel | output | 3 | Channel for the analog multiplexer |
| pwr_on | output | 1 | Converter power request |
| irq | output | 1 | Completion interrupt |

## Verification
The bench checks the exact completion edge at delay values 0, 1 and 63. An off-by-one settle counter would move the interrupt by a cycle, and a counter that mishandles zero would wait through a full 64-cycle wrap. Full-scale, zero, and codes one LSB apart expose an approximation that drops the last bit or tests bits in the wrong order. Aborts in both the settle phase and the bit phase catch a design that still writes a partial code or raises the flag. A check that the flag survives a bit-6-set write and shows once enable is set catches a flag that is wiped by every control write.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_CONV = 2'd2
    } seq_state_e;

    localparam int OFS_RESULT = 'h00;
    localparam int OFS_STATUS = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_DELAY  = 'h0C;

    localparam int CB_CH_LSB  = 0;
    localparam int CB_PWR     = 3;
    localparam int CB_IE      = 5;
    localparam int CB_FLAG    = 6;

    localparam int CH_SEL_W   = 3;
    localparam int DLY_W      = 6;
    localparam int DLY_RESET  = 8;
    localparam int BUS_W      = 32;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                stop,
    input  logic [DLY_W-1:0]    dly,
    input  logic                cmp_ge,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] result,
    output logic [RES_BITS-1:0] trial_code
);

    localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
    localparam logic [IDX_W-1:0] IDX_MSB = IDX_W'(RES_BITS - 1);
    localparam logic [RES_BITS-1:0] ONE = RES_BITS'(1);

    typedef struct packed {
        seq_state_e           state;
        logic [DLY_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [RES_BITS-1:0]  acc;
    } seq_t;

    seq_t q, d;
    logic [RES_BITS-1:0] trial;

    always_comb begin
        d     = q;
        done  = 1'b0;
        trial = (q.state == SEQ_CONV) ? (q.acc | (ONE << q.idx)) : '0;
        if (stop) begin
            d.state = SEQ_IDLE;
        end else if (start) begin
            d.acc = '0;
            d.idx = IDX_MSB;
            d.cnt = dly;
            d.state = (dly == '0) ? SEQ_CONV : SEQ_WAIT;
        end else begin
            unique case (q.state)
                SEQ_WAIT: begin
                    if (q.cnt == DLY_W'(1)) begin
                        d.state = SEQ_CONV;
                        d.idx   = IDX_MSB;
                        d.acc   = '0;
                    end else begin
                        d.cnt = q.cnt - DLY_W'(1);
                    end
                end
                SEQ_CONV: begin
                    d.acc = cmp_ge ? trial : q.acc;
                    if (q.idx == '0) begin
                        done    = 1'b1;
                        d.state = SEQ_IDLE;
                    end else begin
                        d.idx = q.idx - IDX_W'(1);
                    end
                end
                default: d.state = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SEQ_IDLE, cnt: '0, idx: '0, acc: '0};
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.state != SEQ_IDLE);
    assign result     = d.acc;
    assign trial_code = trial;

    // R4: settle phase hands over to the bit phase when the count expires
    assert_wait_to_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SEQ_WAIT && q.cnt == DLY_W'(1) && !start && !stop)
        |=> (q.state == SEQ_CONV && q.idx == IDX_MSB));

    // R5: bit phase walks down one index per cycle
    assert_bit_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SEQ_CONV && q.idx != '0 && !start && !stop)
        |=> (q.state == SEQ_CONV && q.idx == $past(q.idx) - IDX_W'(1)));

    // R8: a power-off write leaves the sequencer idle
    assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !busy);

endmodule

// File: rtl/sar_regs.sv
module sar_regs
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int ADDR_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [BUS_W-1:0]    pwdata,
    output logic [BUS_W-1:0]    prdata,
    input  logic                busy,
    input  logic                done,
    input  logic [RES_BITS-1:0] result,
    output logic                start,
    output logic                stop,
    output logic [CH_SEL_W-1:0] ch,
    output logic                pwr,
    output logic                ie,
    output logic                flag,
    output logic [DLY_W-1:0]    dly
);

    typedef struct packed {
        logic [CH_SEL_W-1:0] ch;
        logic                pwr;
        logic                ie;
        logic                flag;
        logic [DLY_W-1:0]    dly;
        logic [RES_BITS-1:0] data;
    } reg_t;

    reg_t q, d;
    logic wr, ctrl_wr, dly_wr;
    logic unused_wdata;

    assign wr      = psel & penable & pwrite;
    assign ctrl_wr = wr && (paddr == ADDR_W'(OFS_CTRL));
    assign dly_wr  = wr && (paddr == ADDR_W'(OFS_DELAY));
    assign start   = ctrl_wr &  pwdata[CB_PWR];
    assign stop    = ctrl_wr & ~pwdata[CB_PWR];
    assign unused_wdata = ^{pwdata[BUS_W-1:CB_FLAG+1], pwdata[4]};

    always_comb begin
        d = q;
        if (ctrl_wr) begin
            d.ch   = pwdata[CB_CH_LSB +: CH_SEL_W];
            d.pwr  = pwdata[CB_PWR];
            d.ie   = pwdata[CB_IE];
            d.flag = q.flag & pwdata[CB_FLAG];
        end
        if (dly_wr) begin
            d.dly = pwdata[DLY_W-1:0];
        end
        if (done) begin
            d.data = result;
            d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ch: '0, pwr: 1'b0, ie: 1'b0, flag: 1'b0,
                   dly: DLY_W'(DLY_RESET), data: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            unique case (paddr)
                ADDR_W'(OFS_RESULT): prdata[RES_BITS-1:0] = q.data;
                ADDR_W'(OFS_STATUS): prdata[0] = busy;
                ADDR_W'(OFS_CTRL): begin
                    prdata[CB_CH_LSB +: CH_SEL_W] = q.ch;
                    prdata[CB_PWR]  = q.pwr;
                    prdata[CB_IE]   = q.ie;
                    prdata[CB_FLAG] = q.flag;
                end
                ADDR_W'(OFS_DELAY):  prdata[DLY_W-1:0] = q.dly;
                default:             prdata = '0;
            endcase
        end
    end

    assign ch   = q.ch;
    assign pwr  = q.pwr;
    assign ie   = q.ie;
    assign flag = q.flag;
    assign dly  = q.dly;

    // R6: a finished conversion always leaves the flag raised
    assert_done_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag);

    // R8: the result register only moves on completion
    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(q.data));

    // R7: with power off the sequencer is never busy
    assert_off_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !q.pwr |-> !busy);

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int NUM_CH   = 3,
    parameter int ADDR_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [31:0]         pwdata,
    output logic [31:0]         prdata,
    input  logic                cmp_ge,
    output logic [RES_BITS-1:0] trial_code,
    output logic [2:0]          chan_sel,
    output logic                pwr_on,
    output logic                irq
);

    localparam int CH_LIMIT = 1 << CH_SEL_W;

    logic                busy, done, start, stop;
    logic                ie, flag, pwr;
    logic [RES_BITS-1:0] result;
    logic [CH_SEL_W-1:0] ch;
    logic [DLY_W-1:0]    dly;

    initial begin
        assert (NUM_CH >= 1 && NUM_CH <= CH_LIMIT && RES_BITS >= 2 && RES_BITS <= BUS_W)
            else $error("sar_adc_ctrl: parameter out of range");
    end

    sar_regs #(.RES_BITS(RES_BITS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .busy(busy), .done(done), .result(result),
        .start(start), .stop(stop),
        .ch(ch), .pwr(pwr), .ie(ie), .flag(flag), .dly(dly)
    );

    sar_seq #(.RES_BITS(RES_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .stop(stop), .dly(dly), .cmp_ge(cmp_ge),
        .busy(busy), .done(done), .result(result), .trial_code(trial_code)
    );

    assign chan_sel = ch;
    assign pwr_on   = pwr;
    assign irq      = flag & ie;

    // R3: a power-on control write makes the converter busy next cycle
    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R7: writing zero to control drops the interrupt
    assert_clear_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && pwdata[CB_FLAG] == 1'b0) |=> !irq);

endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;

    localparam int RES = 10;
    localparam int AW  = 5;
    localparam int NV  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0]  paddr = '0;
    logic [31:0]    pwdata = '0;
    logic [31:0]    prdata;
    logic           cmp_ge;
    logic [RES-1:0] trial_code;
    logic [2:0]     chan_sel;
    logic           pwr_on, irq;
    logic [RES-1:0] vin = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign cmp_ge = (vin >= trial_code);

    sar_adc_ctrl #(.RES_BITS(RES), .NUM_CH(3), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cmp_ge(cmp_ge),
        .trial_code(trial_code), .chan_sel(chan_sel), .pwr_on(pwr_on), .irq(irq)
    );

    // vector: [19:17] channel, [16:11] delay, [10] irq enable, [9:0] input level
    localparam logic [19:0] VECS [NV] = '{
        {3'd0, 6'd8,  1'b1, 10'd512},
        {3'd1, 6'd0,  1'b1, 10'd0},
        {3'd2, 6'd1,  1'b1, 10'd1023},
        {3'd1, 6'd3,  1'b0, 10'd341},
        {3'd5, 6'd2,  1'b1, 10'd682},
        {3'd7, 6'd63, 1'b1, 10'd1},
        {3'd0, 6'd5,  1'b1, 10'd1022},
        {3'd2, 6'd0,  1'b0, 10'd513}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] v);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = v; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] v);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 v = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] last;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(5'h00, rd); check("R1 result", rd, 0);
        bus_read(5'h04, rd); check("R1 status", rd, 0);
        bus_read(5'h08, rd); check("R1 control", rd, 0);
        bus_read(5'h0C, rd); check("R1 delay", rd, 8);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 pwr_on", {31'd0, pwr_on}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  ch  = VECS[i][19:17];
            logic [5:0]  dl  = VECS[i][16:11];
            logic        en  = VECS[i][10];
            logic [31:0] cw  = 32'(ch) | 32'h8 | (en ? 32'h20 : 32'h0);
            vin = VECS[i][9:0];
            bus_write(5'h0C, 32'(dl));
            bus_write(5'h08, cw);
            bus_read(5'h04, rd); check("R3 busy after start", rd, 1);
            repeat (int'(dl) + RES - 1 - 3) @(negedge clk);
            check("R4 not yet done", {31'd0, irq}, 0);
            check("R9 channel shown", 32'(chan_sel), 32'(ch));
            @(negedge clk);
            check("R4 R6 irq at completion", {31'd0, irq}, 32'(en));
            bus_read(5'h04, rd); check("R4 idle after completion", rd, 0);
            bus_read(5'h00, rd); check("R5 result", rd, 32'(vin));
            bus_read(5'h08, rd); check("R2 R6 control readback", rd, cw | 32'h40);
            if (!en) begin
                bus_write(5'h08, 32'h60);
                check("R6 enable exposes pending flag", {31'd0, irq}, 1);
            end
            bus_write(5'h08, 32'h0);
            check("R7 irq cleared", {31'd0, irq}, 0);
            check("R7 power down", {31'd0, pwr_on}, 0);
            bus_read(5'h08, rd); check("R7 control cleared", rd, 0);
        end
        last = 32'd513;

        // R10 writes to result and status are ignored; undefined offsets read 0
        bus_write(5'h00, 32'h3FF);
        bus_read(5'h00, rd); check("R10 result write ignored", rd, last);
        bus_write(5'h04, 32'h1);
        bus_read(5'h04, rd); check("R10 status write ignored", rd, 0);
        bus_read(5'h10, rd); check("R10 undefined offset", rd, 0);
        bus_read(5'h1C, rd); check("R10 undefined offset high", rd, 0);

        // R8 abort in the settle phase
        vin = 10'd77;
        bus_write(5'h0C, 32'd20);
        bus_write(5'h08, 32'h28);
        repeat (5) @(negedge clk);
        bus_write(5'h08, 32'h0);
        bus_read(5'h04, rd); check("R8 busy cleared after abort", rd, 0);
        repeat (40) @(negedge clk);
        check("R8 no irq after abort", {31'd0, irq}, 0);
        bus_read(5'h00, rd); check("R8 result kept", rd, last);

        // R8 abort in the bit phase, enable left set
        bus_write(5'h0C, 32'd0);
        bus_write(5'h08, 32'h29);
        repeat (3) @(negedge clk);
        bus_write(5'h08, 32'h20);
        repeat (20) @(negedge clk);
        bus_read(5'h08, rd); check("R8 flag not raised", rd, 32'h20);
        bus_read(5'h00, rd); check("R8 result kept in bit phase", rd, last);
        check("R8 irq low", {31'd0, irq}, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule